// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Pair

This block holds the two digital dividers of an integer-N frequency synthesizer. The reference path counts reference-clock cycles and emits a one-cycle pulse every R of them. The feedback path models a dual-modulus prescaler, which divides by P or P+1. A swallow count A and a main count B steer the prescaler, so the feedback pulse arrives once every P*B + A oscillator cycles. Both pulse streams feed a phase detector outside this block.

The block runs in one clock domain. Each path advances only in cycles where its own count-enable input is high, so the enables stand for the reference-clock and oscillator-clock edges. Settings arrive as parallel inputs. Each divider picks up new settings only when its current period ends, so a period in progress always completes with the values it started with. A synchronous counter-clear input holds both dividers at their start state while it is high.

As an example, take a 10 MHz reference with R = 100, which gives a 100 kHz comparison rate. With prescaler code 2'b10 (P = 32), B = 679 and A = 22, the feedback ratio is 32*679 + 22 = 21750, which puts the oscillator at 2.175 GHz.

Top module: `pulse_swallow_divider`

## Requirements
- R1: After reset, and on every cycle while cnt_clear is high plus the cycle after it, both ref_pulse and fb_pulse are low.
- R2: With r_div = R >= 2, ref_pulse is high for exactly one cycle, and successive pulses are R ref_ce cycles apart.
- R3: With r_div = 0, ref_pulse never rises.
- R4: pre_sel selects the prescaler modulus pair P/P+1 as follows: 2'b00 gives 8/9, 2'b01 gives 16/17, 2'b10 gives 32/33 and 2'b11 gives 64/65. Successive fb_pulse rises are P*b_main + a_swallow vco_ce cycles apart.
- R5: With a_swallow = 0, every prescaler cycle uses modulus P, so the feedback period is P*B.
- R6: With a_swallow = b_main, every prescaler cycle uses modulus P+1, so the feedback period is (P+1)*B.
- R7: A change to a_swallow, b_main or pre_sel during a feedback period does not affect that period. It applies from the next period on.
- R8: A change to r_div during a reference period does not affect that period. It applies from the next period on.
- R9: Each divider counts only the cycles in which its enable (ref_ce or vco_ce) is high. Periods are measured in enabled cycles.
- R10: With R = 100, pre_sel = 2'b10, B = 679 and A = 22, the reference period is 100 and the feedback period is 21750.
- R11: fb_pulse is never high on two consecutive cycles.
- R12: Legal feedback settings satisfy b_main >= 3 and b_main >= a_swallow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clear | input | 1 | Synchronous clear holding both dividers at start |
| ref_ce | input | 1 | Reference-edge count enable |
| vco_ce | input | 1 | Oscillator-edge count enable |
| r_div | input | 14 | Reference divide value R |
| a_swallow | input | 6 | Swallow count A |
| b_main | input | 13 | Main count B |
| pre_sel | input | 2 | Prescaler modulus select |
| ref_pulse | output | 1 | One-cycle pulse per reference period |
| fb_pulse | output | 1 | One-cycle pulse per feedback period |

## Verification
The bench builds the block with its default parameters: a 14-bit R, a 6-bit A, a 13-bit B and a base modulus of 8. These defaults make all four prescaler codes and the full worked example reachable within the run time. At these widths the extremes A = 0 and A = B can be exercised with small B, which keeps those periods short. The example ratio of 21750 stays within the cycle budget even when measured over two back-to-back periods.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int unsigned DEF_R_W     = 14;
    localparam int unsigned DEF_A_W     = 6;
    localparam int unsigned DEF_B_W     = 13;
    localparam int unsigned DEF_SEL_W   = 2;
    localparam int unsigned DEF_BASE_L2 = 3;

    // Lower modulus P of the pair for a given select code.
    function automatic int unsigned pre_modulus(input int unsigned base_log2,
                                                input int unsigned code);
        return 32'd1 << (base_log2 + code);
    endfunction

endpackage

// File: rtl/psd_ref_divider.sv
module psd_ref_divider #(
    parameter int unsigned R_W = psd_pkg::DEF_R_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           ce,
    input  logic [R_W-1:0] div,
    output logic           pulse
);

    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic           pulse;
    } ref_state_t;

    ref_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (ce) begin
            if (st_q.cnt == '0) begin
                // idle: sample the divide value (stays idle while it is zero)
                st_d.cnt = div;
            end else if (st_q.cnt == R_W'(1)) begin
                st_d.cnt   = div;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - R_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // A zero divide value keeps the counter idle and silent.
    assert_ref_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0 && st_q.cnt == '0) |=> (st_q.cnt == '0 && !pulse));

    // A count above one never produces a pulse on the next cycle.
    assert_ref_midcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt > R_W'(1)) |=> !pulse);

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int unsigned SEL_W   = psd_pkg::DEF_SEL_W,
    parameter int unsigned BASE_L2 = psd_pkg::DEF_BASE_L2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ce,
    input  logic             hi_next,
    input  logic [SEL_W-1:0] sel_next,
    output logic             tc
);

    localparam int unsigned CNT_W   = BASE_L2 + (1 << SEL_W);
    localparam int unsigned MAX_MOD = 1 << (BASE_L2 + (1 << SEL_W) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [CNT_W-1:0] modv;

    always_comb begin
        modv = CNT_W'(psd_pkg::pre_modulus(BASE_L2, int'(sel_next)));
        tc   = ce && !clr && (st_q.cnt == '0);
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tc) begin
            // load P (P+1 cycles) or P-1 (P cycles)
            st_d.cnt = hi_next ? modv : modv - CNT_W'(1);
        end else if (ce) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(MAX_MOD));

    assert_pre_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !clr) |=> $stable(st_q.cnt));

endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl #(
    parameter int unsigned A_W   = psd_pkg::DEF_A_W,
    parameter int unsigned B_W   = psd_pkg::DEF_B_W,
    parameter int unsigned SEL_W = psd_pkg::DEF_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tc,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    input  logic [SEL_W-1:0] sel_in,
    output logic             hi_next,
    output logic [SEL_W-1:0] sel_next,
    output logic             pulse
);

    localparam int unsigned X_W = B_W + 1;

    typedef struct packed {
        logic             pend;
        logic [B_W-1:0]   idx;
        logic [A_W-1:0]   a;
        logic [B_W-1:0]   b;
        logic [SEL_W-1:0] sel;
        logic             pulse;
    } sw_state_t;

    sw_state_t      st_d, st_q;
    logic           last;
    logic           reload;
    logic [X_W-1:0] idx_inc;

    always_comb begin
        last     = (st_q.idx == st_q.b - B_W'(1));
        reload   = st_q.pend || last;
        idx_inc  = {1'b0, st_q.idx} + X_W'(1);
        hi_next  = reload ? (a_in != '0) : (idx_inc < X_W'(st_q.a));
        sel_next = reload ? sel_in : st_q.sel;

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clr) begin
            st_d.pend = 1'b1;
            st_d.idx  = '0;
        end else if (tc) begin
            if (reload) begin
                st_d.a     = a_in;
                st_d.b     = b_in;
                st_d.sel   = sel_in;
                st_d.idx   = '0;
                st_d.pulse = !st_q.pend;
                st_d.pend  = 1'b0;
            end else begin
                st_d.idx = st_q.idx + B_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: 1'b1, default: '0};
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    assert_fb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    assert_idx_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && st_q.b >= B_W'(3) && B_W'(st_q.a) <= st_q.b) |-> (st_q.idx < st_q.b));

    assert_mid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !reload && !clr) |=> ($stable(st_q.a) && $stable(st_q.b) && $stable(st_q.sel)));

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
    parameter int unsigned R_W     = psd_pkg::DEF_R_W,
    parameter int unsigned A_W     = psd_pkg::DEF_A_W,
    parameter int unsigned B_W     = psd_pkg::DEF_B_W,
    parameter int unsigned SEL_W   = psd_pkg::DEF_SEL_W,
    parameter int unsigned BASE_L2 = psd_pkg::DEF_BASE_L2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clear,
    input  logic             ref_ce,
    input  logic             vco_ce,
    input  logic [R_W-1:0]   r_div,
    input  logic [A_W-1:0]   a_swallow,
    input  logic [B_W-1:0]   b_main,
    input  logic [SEL_W-1:0] pre_sel,
    output logic             ref_pulse,
    output logic             fb_pulse
);

    logic             pre_tc;
    logic             pre_hi;
    logic [SEL_W-1:0] pre_sel_nx;

    psd_ref_divider #(.R_W(R_W)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .ce    (ref_ce),
        .div   (r_div),
        .pulse (ref_pulse)
    );

    psd_prescaler #(.SEL_W(SEL_W), .BASE_L2(BASE_L2)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clear),
        .ce       (vco_ce),
        .hi_next  (pre_hi),
        .sel_next (pre_sel_nx),
        .tc       (pre_tc)
    );

    psd_swallow_ctrl #(.A_W(A_W), .B_W(B_W), .SEL_W(SEL_W)) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clear),
        .tc       (pre_tc),
        .a_in     (a_swallow),
        .b_in     (b_main),
        .sel_in   (pre_sel),
        .hi_next  (pre_hi),
        .sel_next (pre_sel_nx),
        .pulse    (fb_pulse)
    );

    assert_clear_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (!ref_pulse && !fb_pulse));

    assert_fb_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vco_ce |=> !fb_pulse);

endmodule

// File: tb/pulse_swallow_divider_test.sv
module pulse_swallow_divider_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_clear = 1'b0;
    logic        ref_ce = 1'b1;
    logic        vco_ce = 1'b1;
    logic [13:0] r_div = 14'd7;
    logic [5:0]  a_swallow = 6'd0;
    logic [12:0] b_main = 13'd3;
    logic [1:0]  pre_sel = 2'b00;
    logic        ref_pulse;
    logic        fb_pulse;

    int    checks = 0;
    int    fails = 0;
    int    fbq[$];
    string fbtag[$];
    int    refq[$];
    string reftag[$];
    int    fb_cnt = 0, ref_cnt = 0;
    bit    fb_have = 0, ref_have = 0;
    int    fb_total = 0, ref_total = 0, fb_wide = 0;
    bit    fb_prev = 0;
    bit    ce_gap = 0;

    always #2 clk = ~clk;

    pulse_swallow_divider uut (
        .clk(clk), .rst_n(rst_n), .cnt_clear(cnt_clear), .ref_ce(ref_ce),
        .vco_ce(vco_ce), .r_div(r_div), .a_swallow(a_swallow), .b_main(b_main),
        .pre_sel(pre_sel), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitors: sample at the falling edge, count enabled cycles.
    always @(negedge clk) begin
        if (!rst_n || cnt_clear) begin
            fb_have = 0; fb_cnt = 0; ref_have = 0; ref_cnt = 0; fb_prev = 0;
        end else begin
            if (fb_pulse) begin
                fb_total++;
                if (fb_prev) fb_wide++;
                if (fb_have && fbq.size() > 0) chk(fbtag.pop_front(), fb_cnt, fbq.pop_front());
                fb_have = 1; fb_cnt = 0;
            end
            fb_prev = fb_pulse;
            if (vco_ce) fb_cnt++;
            if (ref_pulse) begin
                ref_total++;
                if (ref_have && refq.size() > 0) chk(reftag.pop_front(), ref_cnt, refq.pop_front());
                ref_have = 1; ref_cnt = 0;
            end
            if (ref_ce) ref_cnt++;
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            if (ce_gap) begin vco_ce = ~vco_ce; ref_ce = ~ref_ce; end
        end
    end

    task automatic restart();
        @(posedge clk); #1 cnt_clear = 1'b1;
        @(posedge clk); #1 cnt_clear = 1'b0;
    endtask

    task automatic push_fb(input int exp, input int n, input string tag);
        for (int i = 0; i < n; i++) begin fbq.push_back(exp); fbtag.push_back(tag); end
    endtask

    task automatic push_ref(input int exp, input int n, input string tag);
        for (int i = 0; i < n; i++) begin refq.push_back(exp); reftag.push_back(tag); end
    endtask

    task automatic fb_run(input int a, input int b, input int sel, input int n, input string tag);
        a_swallow = 6'(a); b_main = 13'(b); pre_sel = 2'(sel);
        restart();
        push_fb((8 << sel) * b + a, n, tag);
        wait (fbq.size() == 0);
    endtask

    task automatic ref_run(input int r, input int n, input string tag);
        r_div = 14'(r);
        restart();
        push_ref(r, n, tag);
        wait (refq.size() == 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        int t0, t1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset ref_pulse", int'(ref_pulse), 0);
        chk("R1 reset fb_pulse", int'(fb_pulse), 0);
        rst_n = 1'b1;

        // R1: clear held, short settings, no pulses at all
        r_div = 14'd2; a_swallow = 6'd1; b_main = 13'd3; pre_sel = 2'b00;
        @(posedge clk); #1 cnt_clear = 1'b1;
        t0 = fb_total + ref_total;
        repeat (300) @(posedge clk);
        #1 cnt_clear = 1'b0;
        chk("R1 pulses during clear", fb_total + ref_total - t0, 0);

        // R2 / R8 reference period and late change
        ref_run(7, 3, "R2 ref period 7");
        r_div = 14'd9;
        push_ref(7, 1, "R8 period in progress");
        push_ref(9, 2, "R8 new value");
        wait (refq.size() == 0);

        // R3 zero divide
        r_div = 14'd0;
        restart();
        t0 = ref_total;
        repeat (300) @(posedge clk);
        chk("R3 ref pulses with R=0", ref_total - t0, 0);

        // R4 each prescaler code
        fb_run(2, 5, 0, 2, "R4 code 00");
        fb_run(3, 4, 1, 2, "R4 code 01");
        fb_run(5, 10, 3, 2, "R4 code 11");
        // R5 / R6 extremes of A
        fb_run(0, 4, 0, 2, "R5 A=0");
        fb_run(6, 6, 0, 2, "R6 A=B");
        // R12 legal minimum B
        fb_run(3, 3, 0, 2, "R12 B=3 A=B");

        // R7 change mid-period
        fb_run(1, 5, 0, 1, "R7 start");
        a_swallow = 6'd4; b_main = 13'd7; pre_sel = 2'b01;
        push_fb(41, 1, "R7 period in progress");
        push_fb(116, 2, "R7 new settings");
        wait (fbq.size() == 0);

        // R9 enables toggling every cycle
        ce_gap = 1;
        fb_run(2, 4, 0, 2, "R9 gated fb");
        ref_run(6, 2, "R9 gated ref");
        ce_gap = 0;
        @(posedge clk); #1 vco_ce = 1'b1; ref_ce = 1'b1;

        // R10 worked example
        r_div = 14'd100; a_swallow = 6'd22; b_main = 13'd679; pre_sel = 2'b10;
        restart();
        push_ref(100, 3, "R10 ref example");
        push_fb(21750, 2, "R10 fb example");
        wait (fbq.size() == 0 && refq.size() == 0);

        chk("R11 fb_pulse wider than one cycle", fb_wide, 0);
        t1 = fb_total;
        chk("R11 fb pulses observed", int'(t1 > 20), 1);
        finish_run();
    end

endmodule